// File: doc/BRIEF.md
# Two-Stage SCL Rate Divider

This block produces the bit-timing strobes that an I2C master's transfer engine uses to move SCL. Two programmable dividers are chained. The first divides the system clock by (A+1), where A is a 2-bit value. The second divides the result by (B+1), where B is a 6-bit value. Each tick out of the cascade is one sub-tick, and every SCL period is 22 sub-ticks long. The first 11 sub-ticks are the low half and the last 11 are the high half. One SCL period therefore lasts 22·(A+1)·(B+1) clock cycles, so the fastest rate is the system clock divided by 22. Software picks A and B for a target of 400 kHz or less, with 100 kHz as the usual default.

The engine holds `run` high while it wants clock activity. The block raises three single-cycle strobes:
- `scl_fall` tells the engine to pull SCL low, and marks the start of each period.
- `scl_rise` tells it to release SCL.
- `scl_sample` marks the middle of the high half, where SDA should be read.

The divisor inputs are captured when a run starts and again at each period boundary. A change made in the middle of a period therefore never produces a short or torn period. During the high half, the block watches the real SCL level on `scl_in`. While a slave holds SCL low, the whole timing cascade is frozen.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, and for as long as `run` stays low, `scl_fall`, `scl_rise` and `scl_sample` all stay 0.
- R2: When `run` is first seen high at a clock edge, `scl_fall` pulses in the cycle that follows that edge.
- R3: Consecutive `scl_fall` pulses during a run are exactly 22·(A+1)·(B+1) cycles apart. The shortest possible period is 22 cycles, when A=0 and B=0.
- R4: `scl_rise` pulses 11·(A+1)·(B+1) cycles after the `scl_fall` that opened the period.
- R5: `scl_sample` pulses 16·(A+1)·(B+1) cycles after `scl_fall`, which is five sub-ticks into the high half.
- R6: Each strobe is a one-cycle pulse, and no two strobes are high in the same cycle.
- R7: A change to `div_a` or `div_b` during a period does not alter that period. The new values take effect from the next `scl_fall`.
- R8: The divisor values present when a run starts set the timing of the first period.
- R9: During the high half, every cycle in which `scl_in` is 0 freezes the timing, so `scl_sample` and the next `scl_fall` are each delayed by one cycle per cycle held. A low `scl_in` during the low half has no effect.
- R10: From the cycle after `run` is sampled low, no strobe is issued. A later rising `run` starts a fresh period, as described in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Engine requests SCL activity while high |
| div_a | input | 2 | First-stage divisor A (divide by A+1) |
| div_b | input | 6 | Second-stage divisor B (divide by B+1) |
| scl_in | input | 1 | Sensed SCL line level (1 = high) |
| scl_fall | output | 1 | Strobe: drive SCL low, period start |
| scl_rise | output | 1 | Strobe: release SCL high |
| scl_sample | output | 1 | Strobe: sample SDA at mid-high |

## Verification
If a prescaler count or the phase counter goes wrong, the spacing of the strobes changes. The error shows up within one SCL period as a rise, sample or fall landing at the wrong cycle offset from the preceding fall. If the divisor latch loads at the wrong time, the period in which a divisor change was made comes out with the wrong length. Checking that period's length exposes the fault at the first boundary after the change. A stall decode fault appears as a sample or fall arriving early, or never arriving, during a held-low high phase.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  // One-cycle strobes handed to the transfer engine.
  typedef struct packed {
    logic fall;
    logic rise;
    logic sample;
  } scl_strobe_t;

  localparam int DEF_LOW_TICKS  = 11;
  localparam int DEF_HIGH_TICKS = 11;
  localparam int DEF_SAMPLE_OFS = 5;

endpackage

// File: rtl/scl_div_stage.sv
// One programmable divide-by-(limit+1) stage of the cascade.
module scl_div_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else if (en)     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/scl_phase_seq.sv
// Counts sub-ticks inside one SCL period and emits registered strobes.
module scl_phase_seq
  import scl_rate_pkg::*;
#(
  parameter int LOW_TICKS  = DEF_LOW_TICKS,
  parameter int HIGH_TICKS = DEF_HIGH_TICKS,
  parameter int SAMPLE_OFS = DEF_SAMPLE_OFS,
  localparam int TOTAL     = LOW_TICKS + HIGH_TICKS,
  localparam int PH_W      = $clog2(TOTAL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            start,
  input  logic            subtick,
  output logic [PH_W-1:0] phase,
  output logic            boundary,
  output scl_strobe_t     strobe
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TOTAL - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(LOW_TICKS - 1);
  localparam logic [PH_W-1:0] PH_SAMP = PH_W'(LOW_TICKS + SAMPLE_OFS - 1);

  assign boundary = subtick && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= '0;
    else if (clr)      phase <= '0;
    else if (subtick)  phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe <= '0;
    end else begin
      strobe.fall   <= start || boundary;
      strobe.rise   <= subtick && (phase == PH_RISE);
      strobe.sample <= subtick && (phase == PH_SAMP);
    end
  end

endmodule

// File: rtl/scl_rate_gen.sv
// Top: two cascaded divisors feeding a 22-sub-tick SCL phase sequencer.
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int A_W        = 2,
  parameter int B_W        = 6,
  parameter int LOW_TICKS  = DEF_LOW_TICKS,
  parameter int HIGH_TICKS = DEF_HIGH_TICKS,
  parameter int SAMPLE_OFS = DEF_SAMPLE_OFS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [A_W-1:0] div_a,
  input  logic [B_W-1:0] div_b,
  input  logic           scl_in,
  output logic           scl_fall,
  output logic           scl_rise,
  output logic           scl_sample
);

  localparam int TOTAL = LOW_TICKS + HIGH_TICKS;
  localparam int PH_W  = $clog2(TOTAL);
  localparam logic [PH_W-1:0] PH_HIGH0 = PH_W'(LOW_TICKS);

  logic            active;
  logic            run_go;
  logic            start;
  logic            clr;
  logic            stall;
  logic            cnt_en;
  logic            tick_a;
  logic            subtick;
  logic            boundary;
  logic [PH_W-1:0] phase;
  logic [A_W-1:0]  lat_a;
  logic [B_W-1:0]  lat_b;
  scl_strobe_t     strobe;

  assign run_go = active && run;
  assign start  = run && !active;
  assign clr    = !run_go;
  // Slave stretch: high half with the line still read low freezes everything.
  assign stall  = run_go && (phase >= PH_HIGH0) && !scl_in;
  assign cnt_en = run_go && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) active <= 1'b0;
    else        active <= run;
  end

  // Divisors track the inputs while idle, then reload only at a period edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
    end else if (!run_go || boundary) begin
      lat_a <= div_a;
      lat_b <= div_b;
    end
  end

  scl_div_stage #(.W(A_W)) u_stage_a (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (cnt_en),
    .limit (lat_a),
    .tick  (tick_a)
  );

  scl_div_stage #(.W(B_W)) u_stage_b (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (tick_a),
    .limit (lat_b),
    .tick  (subtick)
  );

  scl_phase_seq #(
    .LOW_TICKS  (LOW_TICKS),
    .HIGH_TICKS (HIGH_TICKS),
    .SAMPLE_OFS (SAMPLE_OFS)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .start    (start),
    .subtick  (subtick),
    .phase    (phase),
    .boundary (boundary),
    .strobe   (strobe)
  );

  assign scl_fall   = strobe.fall;
  assign scl_rise   = strobe.rise;
  assign scl_sample = strobe.sample;

endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk #(
  parameter int MIN_GAP = 21
) (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic scl_in,
  input logic scl_fall,
  input logic scl_rise,
  input logic scl_sample
);

  logic        hi;
  logic        started;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi      <= 1'b0;
      started <= 1'b0;
      gap     <= '0;
    end else begin
      if (!run || scl_fall) hi <= 1'b0;
      else if (scl_rise)    hi <= 1'b1;
      if (!run)             started <= 1'b0;
      else if (scl_fall)    started <= 1'b1;
      if (scl_fall)         gap <= '0;
      else if (gap != 32'hFFFF_FFFF) gap <= gap + 1;
    end
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall, scl_rise, scl_sample}));

  // R6
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_fall);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(scl_fall || scl_rise || scl_sample));

  // R3
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && started) |-> (gap >= 32'(MIN_GAP)));

  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && run && !scl_in) |=> !(scl_sample || scl_fall));

  // R5
  sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_sample |-> hi);

endmodule

bind scl_rate_gen scl_rate_chk #(.MIN_GAP(LOW_TICKS + HIGH_TICKS - 1)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .scl_in     (scl_in),
  .scl_fall   (scl_fall),
  .scl_rise   (scl_rise),
  .scl_sample (scl_sample)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [1:0] div_a = '0;
  logic [5:0] div_b = '0;
  logic       drv = 1'b0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_fall, scl_rise, scl_sample;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = !(drv || hold);

  // Bench model of the open-drain line driven by the master.
  always @(negedge clk) begin
    if (!run)          drv <= 1'b0;
    else if (scl_fall) drv <= 1'b1;
    else if (scl_rise) drv <= 1'b0;
  end

  scl_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_a(div_a), .div_b(div_b),
    .scl_in(scl_in), .scl_fall(scl_fall), .scl_rise(scl_rise),
    .scl_sample(scl_sample)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit sel(input int kind);
    case (kind)
      0: sel = scl_fall;
      1: sel = scl_rise;
      default: sel = scl_sample;
    endcase
  endfunction

  task automatic wait_ev(input int kind, input int lim, output int t);
    t = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (sel(kind)) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic count_strobes(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (scl_fall || scl_rise || scl_sample) c++;
    end
  endtask

  task automatic start_run(input int a, input int b, output int tr);
    @(negedge clk);
    div_a = 2'(a);
    div_b = 6'(b);
    run = 1'b1;
    tr = cyc;
  endtask

  task automatic stop_run();
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    int c;
    chk("R1 fall in reset", int'(scl_fall), 0);
    chk("R1 rise in reset", int'(scl_rise), 0);
    chk("R1 sample in reset", int'(scl_sample), 0);
    @(negedge clk);
    rst_n = 1'b1;
    count_strobes(40, c);
    chk("R1 idle strobes", c, 0);
  endtask

  task automatic t_fastest();
    int tr, t0, t1, t2, t3;
    start_run(0, 0, tr);
    wait_ev(0, 10, t0);
    chk("R2 start latency", t0 - tr, 1);
    wait_ev(1, 100, t1);
    chk("R4 rise offset M=1", t1 - t0, 11);
    wait_ev(2, 100, t2);
    chk("R5 sample offset M=1", t2 - t0, 16);
    wait_ev(0, 100, t3);
    chk("R3 period M=1", t3 - t0, 22);
    stop_run();
  endtask

  task automatic t_slowest();
    int tr, t0, t1, t2, t3;
    start_run(3, 63, tr);
    wait_ev(0, 10, t0);
    chk("R8 start latency M=256", t0 - tr, 1);
    wait_ev(1, 10000, t1);
    chk("R4 rise offset M=256", t1 - t0, 2816);
    wait_ev(2, 10000, t2);
    chk("R5 sample offset M=256", t2 - t0, 4096);
    wait_ev(0, 10000, t3);
    chk("R3 period M=256", t3 - t0, 5632);
    stop_run();
  endtask

  task automatic t_mixed();
    int tr, t0, t1, t2, t3;
    start_run(1, 2, tr);
    wait_ev(0, 10, t0);
    wait_ev(1, 1000, t1);
    chk("R4 rise offset M=6", t1 - t0, 66);
    wait_ev(2, 1000, t2);
    chk("R5 sample offset M=6", t2 - t0, 96);
    wait_ev(0, 1000, t3);
    chk("R3 period M=6", t3 - t0, 132);
    stop_run();
  endtask

  task automatic t_reload();
    int tr, t0, t1, t2, t3;
    start_run(0, 1, tr);
    wait_ev(0, 10, t0);
    wait_ev(1, 1000, t1);
    div_a = 2'd2;
    div_b = 6'd0;
    wait_ev(0, 1000, t2);
    chk("R7 period after mid change", t2 - t0, 44);
    wait_ev(0, 1000, t3);
    chk("R7 period with new divisors", t3 - t2, 66);
    stop_run();
  endtask

  task automatic t_stretch();
    int tr, t0, t1, t2, t3, t4;
    start_run(0, 0, tr);
    wait_ev(0, 10, t0);
    hold = 1'b1;
    repeat (5) @(negedge clk);
    hold = 1'b0;
    wait_ev(1, 100, t1);
    chk("R9 low-half hold ignored", t1 - t0, 11);
    hold = 1'b1;
    repeat (7) @(negedge clk);
    hold = 1'b0;
    wait_ev(2, 100, t2);
    chk("R9 sample delayed by hold", t2 - t0, 23);
    wait_ev(0, 100, t3);
    chk("R9 fall delayed by hold", t3 - t0, 29);
    wait_ev(0, 100, t4);
    chk("R9 next period normal", t4 - t3, 22);
    stop_run();
  endtask

  task automatic t_stop_restart();
    int tr, t0, t1, c, t2, t3;
    start_run(1, 2, tr);
    wait_ev(0, 10, t0);
    wait_ev(1, 1000, t1);
    @(negedge clk);
    run = 1'b0;
    count_strobes(300, c);
    chk("R10 quiet after stop", c, 0);
    start_run(1, 2, tr);
    wait_ev(0, 10, t2);
    chk("R10 restart latency", t2 - tr, 1);
    wait_ev(0, 1000, t3);
    chk("R10 fresh period", t3 - t2, 132);
    stop_run();
  endtask

  task automatic t_excl();
    int overlap = 0;
    int wide = 0;
    int tr;
    bit prev = 0;
    start_run(0, 0, tr);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (int'(scl_fall) + int'(scl_rise) + int'(scl_sample) > 1) overlap++;
      if (prev && scl_fall) wide++;
      prev = scl_fall;
    end
    chk("R6 strobe overlap", overlap, 0);
    chk("R6 fall width", wide, 0);
    stop_run();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fastest();
    t_slowest();
    t_mixed();
    t_reload();
    t_stretch();
    t_stop_restart();
    t_excl();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule